// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the two low-power states of a small microcontroller core: a light sleep, in which only the CPU clock is stopped, and a deep sleep, in which both clocks are gated and the oscillator is turned off. Software raises a one-cycle request for either state. The controller gates the CPU clock, the peripheral clock and the oscillator enable. It also filters the external reset pin into an internal reset and guards on-chip RAM against stray writes in the short window after a reset pin ends a light sleep.

The controller runs from an always-on low-speed clock `clk`, so it keeps working while the main oscillator is off. The external interrupt pins and the reset pin are asynchronous. They pass through `SYNC_STAGES` flip-flops, called D below, before any logic uses them. A machine cycle is `MC_CLKS` clocks, and reset is recognised after RC = 2·`MC_CLKS` clocks. Deep sleep ends through a two-phase handshake on a level-configured external interrupt pin. Driving the pin low restarts the oscillator, and releasing it high returns to full run. A long enough reset pulse also ends deep sleep, and that path keeps RAM.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After `rst_n` is released the controller is in run: `cpu_clk_en`=1, `per_clk_en`=1, `osc_en`=1, `int_rst`=0, `ram_wr_inhibit`=0.
- R2: A `req_idle` pulse sampled in run enters light sleep on that edge: `cpu_clk_en` goes 0 while `per_clk_en` and `osc_en` stay 1.
- R3: In light sleep, `any_irq`=1 sampled at an edge returns to run on that edge.
- R4: A `req_pd` pulse sampled in run enters deep sleep on that edge, with both clock enables and `osc_en` at 0. When `req_pd` and `req_idle` arrive together, deep sleep wins.
- R5: In deep sleep, the following have no effect: `any_irq`, a low interrupt pin whose enable bit is 0, and a low interrupt pin whose `ext_irq_edge` bit is 1 (edge-triggered).
- R6: In deep sleep, an enabled pin with `ext_irq_edge`=0 (level) driven low (the pins are active low) raises `osc_en` D+1 edges later. Both clock enables stay 0.
- R7: Once every qualifying pin is high again, the controller returns to run D+1 edges after the release.
- R8: `int_rst` rises D+RC edges after `rst_pin` goes high, but only if the pin stays high for at least RC clocks with the oscillator on. It falls D+1 edges after the pin goes low. A shorter pulse never asserts it.
- R9: A high `rst_pin` in light sleep restarts the CPU clock D+1 edges later with `ram_wr_inhibit`=1. The inhibit holds until the edge after `int_rst` rises, and the controller is then in run.
- R10: If `rst_pin` drops before recognition during that window, the controller goes back to light sleep with the inhibit cleared.
- R11: A high `rst_pin` in deep sleep turns on `osc_en` (clocks still 0) D+1 edges later. `int_rst` rises RC edges after that, and the controller is in run one edge later.
- R12: Requests are single pulses: after any exit the controller stays in run until a new request arrives.
- R13: Requests are ignored outside run and while `int_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| req_idle | input | 1 | One-cycle light-sleep request |
| req_pd | input | 1 | One-cycle deep-sleep request |
| rst_pin | input | 1 | Raw external reset pin, active high |
| ext_irq_n | input | N_EXT | External interrupt pins, active low |
| ext_irq_en | input | N_EXT | Per-pin interrupt enable |
| ext_irq_edge | input | N_EXT | Per-pin trigger: 1 edge, 0 level |
| any_irq | input | 1 | Some enabled interrupt is pending |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| int_rst | output | 1 | Filtered internal reset |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |

## Verification
The bench sweeps the reset pulse width from one clock to past the recognition threshold and checks `int_rst` on every edge. A filter that was off by one would recognise the pulse one clock short of RC, or rise and fall on the wrong edge. Every pin and enable/trigger combination is tried as a deep-sleep wake source. A controller that woke on an edge-configured or disabled pin, or on `any_irq`, would turn the oscillator on when it should stay off. The reset-during-light-sleep window is checked both to recognition and with a short glitch. A design that left the inhibit set, or stayed halted, would fail one of these checks.

// File: rtl/lpc_pkg.sv
`timescale 1ns/1ps
package lpc_pkg;
   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_IDLE    = 3'd1,
      ST_RSTWIN  = 3'd2,
      ST_PD      = 3'd3,
      ST_PD_WAKE = 3'd4,
      ST_PD_RST  = 3'd5
   } lp_state_e;

   typedef struct packed {
      logic cpu;
      logic per;
      logic osc;
      logic inh;
   } lp_gate_t;
endpackage

// File: rtl/lpc_sync.sv
`timescale 1ns/1ps
module lpc_sync #(
   parameter int          W      = 1,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] INIT  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lpc_rst_filter.sv
`timescale 1ns/1ps
module lpc_rst_filter #(
   parameter int MC_CLKS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_hi,
   input  logic osc_run,
   output logic rec
);
   localparam int RC = 2 * MC_CLKS;
   localparam int CW = $clog2(RC + 1);
   localparam logic [CW-1:0] RC_V = CW'(RC);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (!pin_hi)              cnt <= '0;
      else if (osc_run && cnt != RC_V) cnt <= cnt + 1'b1;
   end

   assign rec = (cnt == RC_V);

   AST_REC_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rec) |-> $past(pin_hi && osc_run));   // R8
   AST_REC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rec && !pin_hi) |=> !rec);   // R8
endmodule

// File: rtl/lpc_wake_qual.sv
`timescale 1ns/1ps
module lpc_wake_qual #(
   parameter int N_EXT = 2
) (
   input  logic [N_EXT-1:0] pin_n,
   input  logic [N_EXT-1:0] en,
   input  logic [N_EXT-1:0] edge_sel,
   output logic             wake_low
);
   logic [N_EXT-1:0] qual;
   generate
      for (genvar i = 0; i < N_EXT; i++) begin : g_pin
         assign qual[i] = en[i] & ~edge_sel[i] & ~pin_n[i];
      end
   endgenerate
   assign wake_low = |qual;
endmodule

// File: rtl/lpc_mode_fsm.sv
`timescale 1ns/1ps
module lpc_mode_fsm
   import lpc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_idle,
   input  logic     req_pd,
   input  logic     rst_s,
   input  logic     rst_rec,
   input  logic     wake_low,
   input  logic     any_irq,
   output lp_gate_t gate
);
   lp_state_e st, st_nx;

   always_comb begin
      st_nx = st;
      if (rst_rec) st_nx = ST_RUN;
      else begin
         unique case (st)
            ST_RUN:     if (req_pd) st_nx = ST_PD;
                        else if (req_idle) st_nx = ST_IDLE;
            ST_IDLE:    if (rst_s) st_nx = ST_RSTWIN;
                        else if (any_irq) st_nx = ST_RUN;
            ST_RSTWIN:  if (!rst_s) st_nx = ST_IDLE;
            ST_PD:      if (rst_s) st_nx = ST_PD_RST;
                        else if (wake_low) st_nx = ST_PD_WAKE;
            ST_PD_WAKE: if (!wake_low) st_nx = ST_RUN;
            ST_PD_RST:  if (!rst_s) st_nx = ST_PD;
            default:    st_nx = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_RUN;
      else        st <= st_nx;
   end

   always_comb begin
      unique case (st)
         ST_RUN:     gate = '{cpu:1'b1, per:1'b1, osc:1'b1, inh:1'b0};
         ST_IDLE:    gate = '{cpu:1'b0, per:1'b1, osc:1'b1, inh:1'b0};
         ST_RSTWIN:  gate = '{cpu:1'b1, per:1'b1, osc:1'b1, inh:1'b1};
         ST_PD:      gate = '{cpu:1'b0, per:1'b0, osc:1'b0, inh:1'b0};
         ST_PD_WAKE: gate = '{cpu:1'b0, per:1'b0, osc:1'b1, inh:1'b0};
         ST_PD_RST:  gate = '{cpu:1'b0, per:1'b0, osc:1'b1, inh:1'b0};
         default:    gate = '{cpu:1'b1, per:1'b1, osc:1'b1, inh:1'b0};
      endcase
   end

   AST_PD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && req_pd && req_idle && !rst_rec) |=> st == ST_PD);   // R4
   AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PD && !wake_low && !rst_s && !rst_rec) |=> st == ST_PD);   // R5
   AST_PD_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PD_WAKE && !wake_low && !rst_rec) |=> st == ST_RUN);   // R7
   AST_INH_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate.inh) |-> $past(st == ST_IDLE));   // R9
endmodule

// File: rtl/lp_mode_ctrl.sv
`timescale 1ns/1ps
module lp_mode_ctrl
   import lpc_pkg::*;
#(
   parameter int N_EXT       = 2,
   parameter int MC_CLKS     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_idle,
   input  logic             req_pd,
   input  logic             rst_pin,
   input  logic [N_EXT-1:0] ext_irq_n,
   input  logic [N_EXT-1:0] ext_irq_en,
   input  logic [N_EXT-1:0] ext_irq_edge,
   input  logic             any_irq,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output logic             osc_en,
   output logic             int_rst,
   output logic             ram_wr_inhibit
);
   generate
      if (N_EXT < 1)       begin : g_bad_n   $error("N_EXT must be at least 1"); end
      if (MC_CLKS < 1)     begin : g_bad_mc  $error("MC_CLKS must be at least 1"); end
      if (SYNC_STAGES < 0) begin : g_bad_syn $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic [N_EXT-1:0] irq_s;
   logic             rst_s, rst_rec, wake_low;
   lp_gate_t         gate;

   lpc_sync #(.W(N_EXT), .STAGES(SYNC_STAGES), .INIT({N_EXT{1'b1}})) i_sync_irq (
      .clk(clk), .rst_n(rst_n), .d(ext_irq_n), .q(irq_s));

   lpc_sync #(.W(1), .STAGES(SYNC_STAGES), .INIT(1'b0)) i_sync_rst (
      .clk(clk), .rst_n(rst_n), .d(rst_pin), .q(rst_s));

   lpc_rst_filter #(.MC_CLKS(MC_CLKS)) i_filt (
      .clk(clk), .rst_n(rst_n), .pin_hi(rst_s), .osc_run(gate.osc), .rec(rst_rec));

   lpc_wake_qual #(.N_EXT(N_EXT)) i_wake (
      .pin_n(irq_s), .en(ext_irq_en), .edge_sel(ext_irq_edge), .wake_low(wake_low));

   lpc_mode_fsm i_fsm (
      .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_pd(req_pd),
      .rst_s(rst_s), .rst_rec(rst_rec), .wake_low(wake_low), .any_irq(any_irq),
      .gate(gate));

   assign cpu_clk_en     = gate.cpu;
   assign per_clk_en     = gate.per;
   assign osc_en         = gate.osc;
   assign int_rst        = rst_rec;
   assign ram_wr_inhibit = gate.inh;

   AST_CLK_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> (!cpu_clk_en && !per_clk_en));   // R4
endmodule

// File: tb/test_lp_mode_ctrl.sv
`timescale 1ns/1ps
module test_lp_mode_ctrl;
   localparam int N  = 2;
   localparam int MC = 3;
   localparam int D  = 2;
   localparam int RC = 2 * MC;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_idle = 0, req_pd = 0, rst_pin = 0, any_irq = 0;
   logic [N-1:0] irq_n = '1, irq_en = '0, irq_edge = '0;
   logic cpu, per, osc, irst, inh;
   int n_cmp = 0, n_bad = 0;

   always #5 clk = ~clk;

   lp_mode_ctrl #(.N_EXT(N), .MC_CLKS(MC), .SYNC_STAGES(D)) i_lp_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_pd(req_pd),
      .rst_pin(rst_pin), .ext_irq_n(irq_n), .ext_irq_en(irq_en),
      .ext_irq_edge(irq_edge), .any_irq(any_irq), .cpu_clk_en(cpu),
      .per_clk_en(per), .osc_en(osc), .int_rst(irst), .ram_wr_inhibit(inh));

   // vector order: cpu, per, osc, int_rst, inhibit
   localparam logic [4:0] V_RUN = 5'b11100, V_IDLE = 5'b01100, V_PD = 5'b00000,
                          V_OSC = 5'b00100, V_WIN = 5'b11101;

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [4:0] exp);
      logic [4:0] act;
      act = {cpu, per, osc, irst, inh};
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_rst(input string tag, input logic exp);
      n_cmp++;
      if (irst !== exp) begin
         n_bad++;
         $display("FAIL %s: int_rst got %b expected %b at %0t", tag, irst, exp, $time);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic enter_pd();
      req_pd = 1; step(1); req_pd = 0;
      chk("R4 enter deep sleep", V_PD);
   endtask

   task automatic wake(input int p);
      irq_en = '0; irq_edge = '0; irq_en[p] = 1'b1;
      irq_n[p] = 1'b0; step(D + 1);
      chk("R6 pin low restarts oscillator", V_OSC);
      step(2);
      chk("R6 clocks held while pin low", V_OSC);
      irq_n[p] = 1'b1; step(D + 1);
      chk("R7 release completes exit", V_RUN);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      step(2);
      rst_n = 1'b1;
      step(1);
      chk("R1 reset state", V_RUN);

      // light sleep entry and exit
      req_idle = 1; step(1); req_idle = 0;
      chk("R2 idle entry", V_IDLE);
      req_pd = 1; step(1); req_pd = 0;
      chk("R13 request ignored in idle", V_IDLE);
      any_irq = 1; step(1); any_irq = 0;
      chk("R3 interrupt ends idle", V_RUN);
      step(3);
      chk("R12 stays in run", V_RUN);

      // simultaneous requests
      req_idle = 1; req_pd = 1; step(1); req_idle = 0; req_pd = 0;
      chk("R4 deep sleep wins", V_PD);
      wake(0);

      // every pin and configuration as a deep-sleep wake source
      for (int p = 0; p < N; p++) begin
         for (int cfg = 0; cfg < 4; cfg++) begin
            logic en_b, ed_b;
            en_b = cfg[0]; ed_b = cfg[1];
            enter_pd();
            irq_en = '0; irq_edge = '0;
            irq_en[p] = en_b; irq_edge[p] = ed_b;
            irq_n[p] = 1'b0; any_irq = 1; step(D + 1); any_irq = 0;
            if (en_b && !ed_b) begin
               chk("R6 qualified pin wakes oscillator", V_OSC);
               irq_n[p] = 1'b1; step(D + 1);
               chk("R7 return to run", V_RUN);
               step(2);
               chk("R12 no re-entry after exit", V_RUN);
            end else begin
               chk("R5 unqualified pin ignored", V_PD);
               irq_n[p] = 1'b1; step(D + 1);
               chk("R5 still in deep sleep", V_PD);
               wake(p);
            end
         end
      end

      // reset pulse width sweep in run
      for (int w = 1; w <= RC + 2; w++) begin
         rst_pin = 1;
         for (int i = 1; i <= w + D + 2; i++) begin
            step(1);
            if (i == w) rst_pin = 0;
            chk_rst("R8 filter width sweep",
                    (w >= RC) && (i >= D + RC) && (i <= D + w));
         end
         step(2);
      end

      // requests ignored while internal reset active
      rst_pin = 1; step(D + RC);
      chk("R8 reset recognised", 5'b11110);
      req_idle = 1; step(1); req_idle = 0;
      chk("R13 request ignored in reset", 5'b11110);
      rst_pin = 0; step(D + 1);
      chk("R8 reset released", V_RUN);

      // reset ends light sleep
      req_idle = 1; step(1); req_idle = 0;
      chk("R2 idle again", V_IDLE);
      rst_pin = 1; step(D + 1);
      chk("R9 window cpu on, RAM inhibited", V_WIN);
      step(RC - 1);
      chk("R9 recognised inside window", 5'b11111);
      step(1);
      chk("R9 run after window", 5'b11110);
      rst_pin = 0; step(D + 1);
      chk("R12 run after reset exit", V_RUN);

      // short glitch during light sleep
      req_idle = 1; step(1); req_idle = 0;
      rst_pin = 1; step(2); rst_pin = 0;
      step(D - 1);
      chk("R10 window opened", V_WIN);
      step(2);
      chk("R10 back to idle", V_IDLE);
      any_irq = 1; step(1); any_irq = 0;
      chk("R3 wake after glitch", V_RUN);

      // reset ends deep sleep
      enter_pd();
      rst_pin = 1; step(D + 1);
      chk("R11 oscillator restarted by reset", V_OSC);
      step(RC - 1);
      chk("R11 not yet recognised", V_OSC);
      step(1);
      chk("R11 recognised", 5'b00110);
      step(1);
      chk("R11 run", 5'b11110);
      rst_pin = 0; step(D + 1);
      chk("R11 reset released", V_RUN);
      step(3);
      chk("R12 no re-entry after reset exit", V_RUN);

      summary();
   end
endmodule